// File: doc/BRIEF.md
# Pipelined Perceptron Inference Core

This block evaluates a small fixed-shape multilayer perceptron in fixed point. It is used to predict how bright a display emitter still is after it has been driven for some time. The three inputs are operating time, drive current and temperature. Each is a signed 16-bit value with 13 fractional bits, already normalised upstream. The single output is the predicted luminance in the same format, paired with a valid strobe.

The network shapes are 3 inputs, three hidden layers of 8 neurons and 1 output neuron. All 185 weights and biases sit in a register array, which is filled once through a write port while a load window is open. A small controller then parks and waits for samples. Four combinational layer stages are separated by pipeline registers. A new sample can enter on every clock, and its result leaves four clocks later. A valid bit travels beside the data, so gaps in the input stream reappear unchanged at the output.

Top module: `mlp_pipe_top`

## Requirements
- R1: During and after reset, `out_vld` is low and all stored parameters are zero. The controller starts in its idle state.
- R2: The controller opens the load window one clock after it sees `wt_vld` and `bias_vld` both high. While the window is open, a write with `ld_we` high stores `ld_data` at word `ld_idx`. Word layout: layer l starts at base 0, 32, 104 or 176. Neuron o of a layer with NI inputs owns words base+o*(NI+1)+i. Its weights come first (i = 0..NI-1), with input 0 = time, 1 = current, 2 = temperature for the first layer. Its bias is at i = NI. Indices of 185 or more are dropped.
- R3: The load window closes when `wt_vld` and `bias_vld` are both low. The controller then waits for samples. After that, writes on the load port have no effect on any result.
- R4: A high `in_vld` while the controller is idle or loading is ignored and never produces an output.
- R5: A sample accepted at clock edge k shows up with `out_vld` high right after edge k+3, which is four registered stages later.
- R6: Back-to-back samples produce back-to-back results. Gaps in `in_vld` reappear as the same gaps in `out_vld`, and results keep their order.
- R7: Each neuron computes acc = bias*2^13 + sum(x_i*w_i) exactly. Its result is floor(acc / 2^13), which is bits [28:13] of the sum.
- R8: If that result does not fit in 16 signed bits, it saturates to 32767 or -32768.
- R9: The three hidden stages replace negative results by zero. The output stage passes its result unchanged.
- R10: Once no input is pending and the pipeline has drained, the controller returns to waiting. It accepts a later burst with the same latency. A fill counter reaches four before the first result of a burst appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_vld | input | 1 | Weight load request |
| bias_vld | input | 1 | Bias load request |
| ld_we | input | 1 | Parameter write strobe |
| ld_idx | input | 8 | Parameter word index |
| ld_data | input | 16 | Parameter word, signed Q2.13 |
| in_vld | input | 1 | Sample valid |
| in_time | input | 16 | Normalised operating time, Q2.13 |
| in_cur | input | 16 | Normalised drive current, Q2.13 |
| in_temp | input | 16 | Normalised temperature, Q2.13 |
| out_vld | output | 1 | Result valid |
| out_lum | output | 16 | Predicted luminance, Q2.13 |

## Verification
The bench sweeps inputs across the full signed range, using two weight sets. The small set keeps most sums in range. The large set forces frequent saturation and ReLU clamping. A design that truncated toward zero instead of flooring, wrapped instead of saturating, or clamped the output stage would miss on many of these samples. The bench also sends samples while the controller is idle or loading, writes after the load window has closed, leaves gaps in the stream, and pauses long enough for the pipeline to drain before a second burst. A controller that accepted early samples, left the write port open, dropped or duplicated results, or stalled after draining would show a missing, extra or shifted `out_vld`, or a wrong value.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

    localparam int DW    = 16;
    localparam int FRAC  = 13;
    localparam int N_IN  = 3;
    localparam int N_HID = 8;
    localparam int N_OUT = 1;
    localparam int N_STG = 4;
    localparam int ACC_W = 2 * DW + 4;

    typedef logic signed [DW-1:0]    q_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_RUN
    } ctrl_st_e;

    function automatic int lyr_ni(input int l);
        return (l == 0) ? N_IN : N_HID;
    endfunction

    function automatic int lyr_no(input int l);
        return (l == N_STG - 1) ? N_OUT : N_HID;
    endfunction

    function automatic int lyr_words(input int l);
        return lyr_no(l) * (lyr_ni(l) + 1);
    endfunction

    function automatic int lyr_base(input int l);
        int s;
        s = 0;
        for (int k = 0; k < l; k++) s += lyr_words(k);
        return s;
    endfunction

    localparam int N_WORDS = lyr_base(N_STG);
    localparam int IDX_W   = $clog2(N_WORDS);

    // Scale back to Q2.13 with floor, saturating on overflow.
    function automatic q_t narrow_q(input acc_t a);
        acc_t s;
        s = a >>> FRAC;
        if ((&s[ACC_W-1:DW-1]) || !(|s[ACC_W-1:DW-1]))
            return s[DW-1:0];
        else if (s[ACC_W-1])
            return {1'b1, {(DW-1){1'b0}}};
        else
            return {1'b0, {(DW-1){1'b1}}};
    endfunction

endpackage

// File: rtl/mlp_layer.sv
module mlp_layer
    import mlp_pkg::*;
#(
    parameter int NI   = 8,
    parameter int NO   = 8,
    parameter bit RELU = 1'b1
) (
    input  logic [NI*DW-1:0]          x_flat,
    input  logic [NO*(NI+1)*DW-1:0]   p_flat,
    output logic [NO*DW-1:0]          y_flat
);

    localparam int REC = NI + 1;

    always_comb begin
        acc_t acc;
        q_t   r;
        y_flat = '0;
        for (int o = 0; o < NO; o++) begin
            acc = acc_t'(q_t'(p_flat[(o*REC+NI)*DW +: DW])) <<< FRAC;
            for (int i = 0; i < NI; i++) begin
                acc = acc + acc_t'(q_t'(x_flat[i*DW +: DW]))
                          * acc_t'(q_t'(p_flat[(o*REC+i)*DW +: DW]));
            end
            r = narrow_q(acc);
            if (RELU && r[DW-1]) r = '0;
            y_flat[o*DW +: DW] = r;
        end
    end

endmodule

// File: rtl/mlp_param_bank.sv
module mlp_param_bank
    import mlp_pkg::*;
#(
    parameter int WORDS = N_WORDS,
    parameter int IW    = IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [WORDS*DW-1:0] prm_flat
);

    logic [WORDS*DW-1:0] prm_d, prm_q;

    always_comb begin
        prm_d = prm_q;
        if (wr_en && (int'(wr_idx) < WORDS))
            prm_d[int'(wr_idx)*DW +: DW] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prm_q <= '0;
        else        prm_q <= prm_d;
    end

    assign prm_flat = prm_q;

endmodule

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
    import mlp_pkg::*;
#(
    parameter int STG = N_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wt_vld,
    input  logic bias_vld,
    input  logic in_vld,
    output logic load_en,
    output logic take,
    output logic out_vld
);

    localparam int FW = $clog2(STG + 1);

    typedef struct packed {
        ctrl_st_e       st;
        logic [FW-1:0]  fill;
        logic [STG-1:0] vld;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        take    = in_vld && ((cur_q.st == ST_WAIT) || (cur_q.st == ST_RUN));
        load_en = (cur_q.st == ST_LOAD);
        nxt_d.vld = {cur_q.vld[STG-2:0], take};
        case (cur_q.st)
            ST_IDLE: if (wt_vld && bias_vld) nxt_d.st = ST_LOAD;
            ST_LOAD: if (!wt_vld && !bias_vld) nxt_d.st = ST_WAIT;
            ST_WAIT: if (in_vld) begin
                nxt_d.st   = ST_RUN;
                nxt_d.fill = FW'(1);
            end
            default: begin
                if (!in_vld && !(|cur_q.vld[STG-2:0])) begin
                    nxt_d.st   = ST_WAIT;
                    nxt_d.fill = '0;
                end else if (cur_q.fill < FW'(STG)) begin
                    nxt_d.fill = cur_q.fill + FW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, fill: '0, vld: '0};
        else        cur_q <= nxt_d;
    end

    assign out_vld = cur_q.vld[STG-1];

    logic [2:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 3'd4)  age_q <= age_q + 3'd1;
    end

    // R5
    latency_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 3'd4) |-> (out_vld == $past(take, 4)));

    // R10
    fill_before_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (cur_q.fill == FW'(STG) && cur_q.st == ST_RUN));

    // R4
    no_result_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_IDLE) || (cur_q.st == ST_LOAD)) |-> !out_vld);

endmodule

// File: rtl/mlp_pipe_top.sv
module mlp_pipe_top
    import mlp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wt_vld,
    input  logic             bias_vld,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic             in_vld,
    input  logic [DW-1:0]    in_time,
    input  logic [DW-1:0]    in_cur,
    input  logic [DW-1:0]    in_temp,
    output logic             out_vld,
    output logic [DW-1:0]    out_lum
);

    localparam int HW = N_HID * DW;

    typedef struct packed {
        logic [N_STG-2:0][HW-1:0] h;
        logic [N_OUT*DW-1:0]      y;
    } pipe_s;

    logic                    load_en;
    logic                    take;
    logic [N_WORDS*DW-1:0]   prm_flat;
    logic [N_STG-2:0][HW-1:0] lyr_out;
    logic [N_OUT*DW-1:0]     fin_y;
    pipe_s                   pipe_q, pipe_d;

    mlp_ctrl #(.STG(N_STG)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wt_vld   (wt_vld),
        .bias_vld (bias_vld),
        .in_vld   (in_vld),
        .load_en  (load_en),
        .take     (take),
        .out_vld  (out_vld)
    );

    mlp_param_bank #(.WORDS(N_WORDS), .IW(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (load_en && ld_we),
        .wr_idx   (ld_idx),
        .wr_data  (ld_data),
        .prm_flat (prm_flat)
    );

    for (genvar l = 0; l < N_STG; l++) begin : g_stage
        localparam int BASE = lyr_base(l);
        localparam int NI   = lyr_ni(l);
        localparam int NO   = lyr_no(l);
        localparam int CNT  = lyr_words(l);
        if (l == 0) begin : g_first
            mlp_layer #(.NI(NI), .NO(NO), .RELU(1'b1)) u_lyr (
                .x_flat (({in_temp, in_cur, in_time})),
                .p_flat (prm_flat[BASE*DW +: CNT*DW]),
                .y_flat (lyr_out[l])
            );
        end else if (l < N_STG - 1) begin : g_mid
            mlp_layer #(.NI(NI), .NO(NO), .RELU(1'b1)) u_lyr (
                .x_flat (pipe_q.h[l-1]),
                .p_flat (prm_flat[BASE*DW +: CNT*DW]),
                .y_flat (lyr_out[l])
            );
        end else begin : g_last
            mlp_layer #(.NI(NI), .NO(NO), .RELU(1'b0)) u_lyr (
                .x_flat (pipe_q.h[l-1]),
                .p_flat (prm_flat[BASE*DW +: CNT*DW]),
                .y_flat (fin_y)
            );
        end
    end

    always_comb begin
        pipe_d   = pipe_q;
        pipe_d.h = lyr_out;
        pipe_d.y = fin_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_lum = pipe_q.y[DW-1:0];

    // R3
    params_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(prm_flat));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_vld && prm_flat == '0));

endmodule

// File: tb/mlp_pipe_top_test.sv
`timescale 1ns/1ps
module mlp_pipe_top_test;

    localparam int NW = 185;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wt_vld, bias_vld, ld_we, in_vld;
    logic [7:0]  ld_idx;
    logic [15:0] ld_data, in_time, in_cur, in_temp;
    logic        out_vld;
    logic [15:0] out_lum;

    int    wset [NW];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    armed = 1'b0;
    bit    done  = 1'b0;
    string vtag  = "R4";
    string dtag  = "R7 R9";
    logic [3:0] hist = '0;
    int    q_exp [$];

    always #2.5 clk = ~clk;

    mlp_pipe_top uut (
        .clk(clk), .rst_n(rst_n), .wt_vld(wt_vld), .bias_vld(bias_vld),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data), .in_vld(in_vld),
        .in_time(in_time), .in_cur(in_cur), .in_temp(in_temp),
        .out_vld(out_vld), .out_lum(out_lum)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int model(input int a, input int b, input int c);
        int cur [8];
        int nxt [8];
        int bases [4] = '{0, 32, 104, 176};
        int nin, nout;
        longint acc;
        cur[0] = a; cur[1] = b; cur[2] = c;
        nin = 3;
        for (int l = 0; l < 4; l++) begin
            nout = (l == 3) ? 1 : 8;
            for (int o = 0; o < nout; o++) begin
                acc = longint'(wset[bases[l] + o*(nin+1) + nin]) * 8192;
                for (int i = 0; i < nin; i++)
                    acc += longint'(cur[i]) * longint'(wset[bases[l] + o*(nin+1) + i]);
                nxt[o] = sat16(acc >>> 13);
                if (l < 3 && nxt[o] < 0) nxt[o] = 0;
            end
            for (int o = 0; o < nout; o++) cur[o] = nxt[o];
            nin = nout;
        end
        return cur[0];
    endfunction

    function automatic int xin(input int n, input int j);
        return ((n * (1237 + 311*j) + 5003*j + 17) % 65536) - 32768;
    endfunction

    always @(posedge clk) begin
        bit a;
        a = rst_n && in_vld && armed;
        if (!rst_n) begin
            hist = '0;
            q_exp.delete();
        end else begin
            hist = {hist[2:0], a};
            if (a) q_exp.push_back(model(int'($signed(in_time)),
                                         int'($signed(in_cur)),
                                         int'($signed(in_temp))));
            #1;
            check(out_vld === hist[3], vtag, "out_vld", int'(out_vld), int'(hist[3]));
            if (out_vld && hist[3] && q_exp.size() > 0) begin
                int e;
                e = q_exp.pop_front();
                check(int'($signed(out_lum)) == e, dtag, "out_lum",
                      int'($signed(out_lum)), e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; armed = 1'b0;
        wt_vld = 0; bias_vld = 0; ld_we = 0; in_vld = 0;
        repeat (2) @(negedge clk);
        #0.5;
        check(out_vld === 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(out_vld === 1'b0, "R1", "out_vld after reset", int'(out_vld), 0);
    endtask

    task automatic load_all();
        vtag = "R4";
        @(negedge clk);
        wt_vld = 1; bias_vld = 1;
        in_vld = 1;                       // R4: sample while idle
        @(negedge clk);
        for (int k = 0; k < NW; k++) begin
            ld_we = 1; ld_idx = 8'(k); ld_data = 16'(wset[k]);
            in_vld = (k < 4);             // R4: samples while loading
            @(negedge clk);
        end
        ld_idx = 8'd200; ld_data = 16'h7fff;   // R2: out of range, dropped
        @(negedge clk);
        ld_we = 0; in_vld = 0; wt_vld = 0; bias_vld = 0;
        @(negedge clk);
        repeat (5) @(negedge clk);
        armed = 1'b1;
    endtask

    task automatic stream(input int n, input int base, input bit gaps);
        for (int j = 0; j < n; j++) begin
            in_time = 16'(xin(base + j, 0));
            in_cur  = 16'(xin(base + j, 1));
            in_temp = 16'(xin(base + j, 2));
            in_vld  = gaps ? ((j % 3) != 1 && (j % 7) != 5) : 1'b1;
            @(negedge clk);
        end
        in_vld = 0;
    endtask

    initial begin
        rst_n = 0; wt_vld = 0; bias_vld = 0; ld_we = 0; in_vld = 0;
        ld_idx = '0; ld_data = '0; in_time = '0; in_cur = '0; in_temp = '0;

        // Weight set A: small magnitudes
        for (int k = 0; k < NW; k++) wset[k] = (((k*37 + 11) % 97) - 48) * 48;
        do_reset();
        vtag = "R4";
        in_vld = 1; repeat (3) @(negedge clk); in_vld = 0;  // R4: idle samples
        load_all();

        // R3: write after the window closed, model keeps old words
        ld_we = 1; ld_idx = 8'd184; ld_data = 16'h7000;
        @(negedge clk);
        ld_idx = 8'd0;
        @(negedge clk);
        ld_we = 0;

        vtag = "R5 R6";
        dtag = "R2 R3 R7 R9";
        stream(256, 0, 1'b0);
        repeat (12) @(negedge clk);
        vtag = "R6 R10";
        dtag = "R10 R7 R9";
        stream(96, 1000, 1'b1);
        repeat (8) @(negedge clk);

        // Weight set B: large magnitudes to force saturation
        for (int k = 0; k < NW; k++) wset[k] = (((k*53 + 7) % 31) - 15) * 1500;
        do_reset();
        load_all();
        vtag = "R5 R6";
        dtag = "R8 R9";
        stream(300, 5000, 1'b0);
        repeat (8) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            finish_run();
        end
    end

endmodule